// File: doc/BRIEF.md
# Interface Activity Detector and Power Arbiter

This block watches two video input paths, one analog and one digital link, and decides which one owns the shared pixel outputs and which circuit groups must stay powered. Activity pulses for horizontal sync, vertical sync, sync-on-green and the digital link clock each keep a presence flag alive. A flag drops a fixed timeout after its last pulse. While the digital path is powered, data-enable pulses are counted, and the digital path is declared to carry video once a set number of them has arrived.

Three control bits steer the choice. A power bit forces absolute power-down. An override bit hands the choice to a select bit. Otherwise the detected activity decides, and the select bit breaks the tie when both paths are active. The result drives a one-hot operating mode, a vector of power-domain enables, a combined sync-detect flag, an output-driver enable and a status byte. All inputs are single-cycle pulses or levels that are synchronous to `clk`. The block has no data stream and therefore no back-pressure; every pin is plain control or status.

Top module: `ifsel_power_ctrl`

## Requirements
- R1: A pulse on an activity input, with power on, sets its presence flag at the edge that samples it. The flag falls exactly TIMEOUT_CYC = (CLK_HZ/1000)*TIMEOUT_MS cycles after the edge that sampled the last pulse.
- R2: The status byte layout is as follows. Bit 7 is horizontal-sync presence, bit 6 vertical-sync presence, bit 5 sync-on-green presence, bit 4 link-clock presence and bit 3 data-enable detect. Bits 2..0 read 0.
- R3: Data-enable detect rises after DE_TARGET (default 32) data-enable pulses have been sampled while the mode is digital. Pulses outside digital mode are ignored, and leaving digital mode discards the count.
- R4: `sync_det` is high when horizontal-sync presence or data-enable detect is high. `out_oe` is high only when `sync_det` is high and the mode is analog or digital.
- R5: `pwr_on` = 0 outranks every other input. One edge later the mode is absolute power-down and every presence flag and the data-enable detect are clear. Activity pulses have no effect while it stays 0.
- R6: With `pwr_on` = 1 and `ovr_en` = 1, the next mode is analog for `ovr_sel` = 0 and digital for `ovr_sel` = 1, whatever activity is present.
- R7: With `ovr_en` = 0, the next mode is chosen from the presence flags. Analog detect is the OR of status bits 7..5, and digital detect is status bit 4. Analog detect alone gives analog, digital detect alone gives digital, and both give the mode chosen by `ovr_sel` (0 analog, 1 digital). Neither gives seek.
- R8: `mode_oh` is one-hot and registered: bit 0 absolute power-down, bit 1 seek, bit 2 analog, bit 3 digital. It follows the flags with one cycle of lag.
- R9: The `pwr_en` bits are: 0 analog core, 1 digital core, 2 sync activity detectors, 3 link-clock detector, 4 sync-on-green slicer, 5 reference, 6 output drivers. The value is 0x00 in power-down, 0x3C in seek, 0x7D in analog and 0x7E in digital.
- R10: During and right after reset the mode is absolute power-down and the status byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_act | input | 1 | Horizontal-sync activity pulse |
| vs_act | input | 1 | Vertical-sync activity pulse |
| sog_act | input | 1 | Sync-on-green activity pulse |
| lclk_act | input | 1 | Digital link clock activity pulse |
| de_pulse | input | 1 | One pulse per data-enable period on the digital link |
| pwr_on | input | 1 | 0 forces absolute power-down |
| ovr_en | input | 1 | 1 hands the interface choice to ovr_sel |
| ovr_sel | input | 1 | Interface choice: 0 analog, 1 digital |
| status | output | 8 | Presence and detect flags (R2) |
| sync_det | output | 1 | Combined sync detect |
| out_oe | output | 1 | Shared data output driver enable |
| mode_oh | output | 4 | One-hot operating mode (R8) |
| pwr_en | output | 7 | Power-domain enables (R9) |

## Verification
The bench uses CLK_HZ = 1000 and TIMEOUT_MS = 100, which gives a 100-cycle presence timeout, and keeps DE_TARGET at 32. With these values the exact falling cycle of a presence flag can be sampled on both sides. The 31/32 data-enable boundary also fits in a short run, as do several flag expiries between mode changes. Keep-alive pulses every eight cycles hold the chosen flags up while the override, tie-break and power-down orderings are walked through.

// File: rtl/ifsel_pkg.sv
package ifsel_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SEEK = 2'd1,
    MODE_ANA  = 2'd2,
    MODE_DIG  = 2'd3
  } mode_e;

  localparam int NUM_MODES = 4;
  localparam int PWR_W     = 7;

  localparam int PE_ANA_CORE = 0;
  localparam int PE_DIG_CORE = 1;
  localparam int PE_SYNC_DET = 2;
  localparam int PE_LCLK_DET = 3;
  localparam int PE_SOG      = 4;
  localparam int PE_REF      = 5;
  localparam int PE_OUT      = 6;

  function automatic logic [PWR_W-1:0] domain_map(mode_e m);
    logic [PWR_W-1:0] v;
    v = '0;
    if (m != MODE_OFF) begin
      v[PE_SYNC_DET] = 1'b1;
      v[PE_LCLK_DET] = 1'b1;
      v[PE_SOG]      = 1'b1;
      v[PE_REF]      = 1'b1;
    end
    if (m == MODE_ANA) begin
      v[PE_ANA_CORE] = 1'b1;
      v[PE_OUT]      = 1'b1;
    end
    if (m == MODE_DIG) begin
      v[PE_DIG_CORE] = 1'b1;
      v[PE_OUT]      = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [NUM_MODES-1:0] mode_onehot(mode_e m);
    return NUM_MODES'(1) << m;
  endfunction

endpackage

// File: rtl/act_timer.sv
module act_timer #(
  parameter int CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pulse,
  output logic present
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (pulse)      cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign present = (cnt != '0);
endmodule

// File: rtl/de_counter.sv
module de_counter #(
  parameter int TARGET = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic de_pulse,
  output logic detected
);
  localparam int CW = $clog2(TARGET + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cnt <= '0;
    else if (!enable)                            cnt <= '0;
    else if (de_pulse && cnt != CW'(TARGET))     cnt <= cnt + 1'b1;
  end

  assign detected = (cnt == CW'(TARGET));
endmodule

// File: rtl/mode_arbiter.sv
module mode_arbiter
  import ifsel_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pwr_on,
  input  logic  ovr_en,
  input  logic  ovr_sel,
  input  logic  ana_det,
  input  logic  dig_det,
  output mode_e mode_q
);
  mode_e mode_d;

  always_comb begin
    if (!pwr_on)                 mode_d = MODE_OFF;
    else if (ovr_en)             mode_d = ovr_sel ? MODE_DIG : MODE_ANA;
    else if (ana_det && dig_det) mode_d = ovr_sel ? MODE_DIG : MODE_ANA;
    else if (ana_det)            mode_d = MODE_ANA;
    else if (dig_det)            mode_d = MODE_DIG;
    else                         mode_d = MODE_SEEK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/ifsel_power_ctrl.sv
module ifsel_power_ctrl
  import ifsel_pkg::*;
#(
  parameter int CLK_HZ     = 27_000_000,
  parameter int TIMEOUT_MS = 100,
  parameter int DE_TARGET  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hs_act,
  input  logic        vs_act,
  input  logic        sog_act,
  input  logic        lclk_act,
  input  logic        de_pulse,
  input  logic        pwr_on,
  input  logic        ovr_en,
  input  logic        ovr_sel,
  output logic [7:0]  status,
  output logic        sync_det,
  output logic        out_oe,
  output logic [3:0]  mode_oh,
  output logic [6:0]  pwr_en
);
  localparam int TIMEOUT_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;
  localparam int NSRC        = 4;

  // index 0 hsync, 1 vsync, 2 sync-on-green, 3 link clock
  logic [NSRC-1:0] act_vec;
  logic [NSRC-1:0] present;
  logic            de_det;
  logic            ana_det;
  logic            dig_det;
  mode_e           mode_q;

  assign act_vec = {lclk_act, sog_act, vs_act, hs_act};

  for (genvar i = 0; i < NSRC; i++) begin : g_timer
    act_timer #(.CYC(TIMEOUT_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!pwr_on),
      .pulse   (act_vec[i]),
      .present (present[i])
    );
  end

  assign ana_det = |present[2:0];
  assign dig_det = present[3];

  de_counter #(.TARGET(DE_TARGET)) u_de (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (pwr_on && (mode_q == MODE_DIG)),
    .de_pulse (de_pulse),
    .detected (de_det)
  );

  mode_arbiter u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_on  (pwr_on),
    .ovr_en  (ovr_en),
    .ovr_sel (ovr_sel),
    .ana_det (ana_det),
    .dig_det (dig_det),
    .mode_q  (mode_q)
  );

  assign status   = {present[0], present[1], present[2], present[3], de_det, 3'b000};
  assign sync_det = present[0] | de_det;
  assign mode_oh  = mode_onehot(mode_q);
  assign pwr_en   = domain_map(mode_q);
  assign out_oe   = sync_det & pwr_en[PE_OUT];
endmodule

// File: rtl/ifsel_power_ctrl_chk.sv
module ifsel_power_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hs_act,
  input logic       pwr_on,
  input logic       ovr_en,
  input logic       ovr_sel,
  input logic [7:0] status,
  input logic       sync_det,
  input logic       out_oe,
  input logic [3:0] mode_oh,
  input logic [6:0] pwr_en
);
  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_oh) == 1); // R8

  AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (mode_oh == 4'b0001 && status == 8'h00)); // R5

  AST_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    mode_oh[0] |-> (pwr_en == 7'h00 && !out_oe)); // R9

  AST_HS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && hs_act) |=> status[7]); // R1

  AST_FORCE_ANA: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && ovr_en && !ovr_sel) |=> mode_oh == 4'b0100); // R6

  AST_FORCE_DIG: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && ovr_en && ovr_sel) |=> mode_oh == 4'b1000); // R6

  AST_DE_IN_DIG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> $past(mode_oh[3])); // R3

  AST_OE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    out_oe |-> sync_det); // R4
endmodule

bind ifsel_power_ctrl ifsel_power_ctrl_chk u_chk (.*);

// File: tb/ifsel_power_ctrl_test.sv
module ifsel_power_ctrl_test;
  localparam int T = 100;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, pwr_on = 1'b0, ovr_en = 1'b0, ovr_sel = 1'b0;
  logic p_hs = 1'b0, p_vs = 1'b0, p_de = 1'b0;
  logic keep_hs = 1'b0, keep_sog = 1'b0, keep_lclk = 1'b0, kp = 1'b0;
  logic hs_act, vs_act, sog_act, lclk_act, de_pulse;
  logic [7:0] status;
  logic sync_det, out_oe;
  logic [3:0] mode_oh;
  logic [6:0] pwr_en;

  assign hs_act   = (keep_hs & kp) | p_hs;
  assign vs_act   = p_vs;
  assign sog_act  = keep_sog & kp;
  assign lclk_act = keep_lclk & kp;
  assign de_pulse = p_de;

  ifsel_power_ctrl #(.CLK_HZ(1000), .TIMEOUT_MS(100), .DE_TARGET(32)) uut (
    .clk(clk), .rst_n(rst_n), .hs_act(hs_act), .vs_act(vs_act), .sog_act(sog_act),
    .lclk_act(lclk_act), .de_pulse(de_pulse), .pwr_on(pwr_on), .ovr_en(ovr_en),
    .ovr_sel(ovr_sel), .status(status), .sync_det(sync_det), .out_oe(out_oe),
    .mode_oh(mode_oh), .pwr_en(pwr_en)
  );

  localparam logic [3:0] M_OFF = 4'b0001, M_SEEK = 4'b0010, M_ANA = 4'b0100, M_DIG = 4'b1000;

  typedef struct {
    string      tag;
    logic [7:0] st;
    logic [3:0] md;
    logic       sy;
    logic       oe;
    logic [6:0] pe;
    bit         full;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // keep-alive phase: one pulse every 8 cycles
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 8;
      kp = (ph == 0);
    end
  end

  function automatic logic [6:0] pe_of(logic [3:0] md);
    case (md)
      M_SEEK:  return 7'h3C;
      M_ANA:   return 7'h7D;
      M_DIG:   return 7'h7E;
      default: return 7'h00;
    endcase
  endfunction

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(string tag, logic [7:0] st, logic [3:0] md, logic sy);
    exp_t e;
    e.tag = tag; e.st = st; e.md = md; e.sy = sy;
    e.oe = sy & (md[2] | md[3]);
    e.pe = pe_of(md); e.full = 1'b1;
    sb.push_back(e);
    wait (sb.size() == 0);
  endtask

  task automatic push_st(string tag, logic [7:0] st);
    exp_t e;
    e.tag = tag; e.st = st; e.md = '0; e.sy = 1'b0; e.oe = 1'b0; e.pe = '0; e.full = 1'b0;
    sb.push_back(e);
    wait (sb.size() == 0);
  endtask

  task automatic de_burst(int n);
    repeat (n) begin
      p_de = 1'b1; @(negedge clk);
      p_de = 1'b0; @(negedge clk);
    end
  endtask

  // monitor: pops expected items and compares against the outputs
  initial begin
    exp_t e;
    forever begin
      wait (sb.size() != 0);
      e = sb.pop_front();
      n_chk++;
      if (e.full) begin
        if (status !== e.st || mode_oh !== e.md || sync_det !== e.sy ||
            out_oe !== e.oe || pwr_en !== e.pe) begin
          n_bad++;
          $display("FAIL %s: st=%h md=%b sy=%b oe=%b pe=%h expected st=%h md=%b sy=%b oe=%b pe=%h",
                   e.tag, status, mode_oh, sync_det, out_oe, pwr_en,
                   e.st, e.md, e.sy, e.oe, e.pe);
        end
      end else if (status !== e.st) begin
        n_bad++;
        $display("FAIL %s: st=%h expected st=%h", e.tag, status, e.st);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    settle(3);
    push("R10 reset state", 8'h00, M_OFF, 1'b0);
    rst_n = 1'b1;
    p_hs = 1'b1; settle(1); p_hs = 1'b0; settle(2);
    push("R5 activity ignored while off", 8'h00, M_OFF, 1'b0);

    pwr_on = 1'b1; settle(3);
    push("R7 no activity gives seek", 8'h00, M_SEEK, 1'b0);

    // single vsync pulse: timeout edge, R1
    p_vs = 1'b1; settle(1); p_vs = 1'b0;
    settle(2);
    push("R7 R2 vsync alone gives analog", 8'h40, M_ANA, 1'b0);
    settle(T - 3);
    push_st("R1 flag still set one cycle before timeout", 8'h40);
    settle(1);
    push_st("R1 flag clear at timeout", 8'h00);
    settle(3);
    push("R7 back to seek", 8'h00, M_SEEK, 1'b0);

    keep_sog = 1'b1; settle(12);
    push("R7 R2 sync-on-green alone gives analog", 8'h20, M_ANA, 1'b0);
    keep_sog = 1'b0; settle(T + 5);

    keep_hs = 1'b1; settle(12);
    push("R4 hsync drives sync_det", 8'h80, M_ANA, 1'b1);
    de_burst(40);
    push("R3 data enables ignored in analog mode", 8'h80, M_ANA, 1'b1);

    keep_lclk = 1'b1; settle(12);
    push("R7 both detected select 0", 8'h90, M_ANA, 1'b1);
    ovr_sel = 1'b1; settle(3);
    push("R7 R3 both detected select 1, no stale count", 8'h90, M_DIG, 1'b1);

    keep_hs = 1'b0; settle(T + 5);
    push("R7 link clock alone gives digital", 8'h10, M_DIG, 1'b0);
    de_burst(31);
    push("R3 31 data enables not enough", 8'h10, M_DIG, 1'b0);
    de_burst(1);
    push("R3 R4 32nd data enable detects", 8'h18, M_DIG, 1'b1);

    ovr_en = 1'b1; ovr_sel = 1'b0; settle(3);
    push("R6 R3 override to analog drops count", 8'h10, M_ANA, 1'b0);
    ovr_sel = 1'b1; settle(3);
    push("R6 R3 override back to digital restarts count", 8'h10, M_DIG, 1'b0);

    keep_lclk = 1'b0; settle(T + 5);
    push("R6 override digital with no activity", 8'h00, M_DIG, 1'b0);
    ovr_sel = 1'b0; settle(3);
    push("R6 override analog with no activity", 8'h00, M_ANA, 1'b0);
    ovr_en = 1'b0; settle(3);
    push("R7 override released gives seek", 8'h00, M_SEEK, 1'b0);

    keep_hs = 1'b1; keep_lclk = 1'b1; ovr_en = 1'b1; ovr_sel = 1'b1; settle(12);
    push("R6 override digital beats hsync", 8'h90, M_DIG, 1'b1);
    pwr_on = 1'b0; settle(2);
    push("R5 R9 power-down outranks everything", 8'h00, M_OFF, 1'b0);
    keep_hs = 1'b0; keep_lclk = 1'b0; ovr_en = 1'b0; ovr_sel = 1'b0;
    pwr_on = 1'b1; settle(3);
    push("R8 power restored gives seek", 8'h00, M_SEEK, 1'b0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule